// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Pseudo Non-Maskable Class

This block gathers up to 32 interrupt sources. It holds each hardware request in a per-source latch and presents one prioritized request to a simple CPU handshake. While `irq_o` is high, the CPU pulses `take_i`. The block then accepts the winning source, clears that source's latch, and reports the source number on `vec_o` with a one-cycle `ack_o`. Return strobes from the CPU restore the master enable.

Source 0 is the software interrupt. It has no latch, and its request is the level on `swi_i`. Source 1 is the watchdog. These two sources form a pseudo non-maskable class: they ignore every enable flag, but a second one is not accepted while the first is still in service. Sources 2 and up are maskable. Software reaches the latches and enables through eight byte locations. It can clear latches but can never set them.

Top module: `irq_ctrl`

## Requirements
- R1: A hardware request on `hw_req_i[k]` sets latch k on the next clock edge. The latch then holds until that source is accepted or software clears it. All latches are 0 after reset.
- R2: Accepting source k clears latch k. A new request on the same source in the accept cycle leaves the latch set.
- R3: Reads are combinational. Addresses 0..3 return enable bytes and addresses 4..7 return latch bytes. In both regions, source k sits at byte k/8, bit k%8. Enable byte 0 bit 0 reads the master enable. Latch byte 0 bit 0 always reads 0.
- R4: A write to a latch byte clears each latch whose data bit is 0 and leaves the latch unchanged where the bit is 1. A hardware set in the same cycle wins over the clear.
- R5: A maskable source k (k >= 2) is eligible only while its latch, its enable flag and the master enable are all 1.
- R6: The lowest-numbered eligible source wins. `take_i` while `irq_o` is high gives `ack_o` = 1 for exactly the next cycle, with `vec_o` equal to the winner. `take_i` with `irq_o` low gives no acknowledge.
- R7: Source 0 (while `swi_i` is 1) and source 1 (while its latch is set) are eligible whatever the master enable and enable flags hold. Enable bit 1 can be stored and read, but it has no effect.
- R8: After a source 0 or 1 is accepted, neither source is eligible until `retn_i` is pulsed.
- R9: Every acceptance clears the master enable. `reti_i` sets the master enable to the value it had just before the most recent maskable acceptance.
- R10: `retn_i` sets the master enable to 1 and ends pseudo non-maskable service.
- R11: Writes to enable bytes update the enable flags, and byte 0 bit 0 writes the master enable. For the master enable, an acceptance takes priority over `retn_i`, `retn_i` over `reti_i`, and `reti_i` over a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 31 | Hardware request per source 1..31 |
| swi_i | input | 1 | Software interrupt request level (source 0) |
| take_i | input | 1 | CPU accepts the pending interrupt |
| reti_i | input | 1 | Return from a maskable service routine |
| retn_i | input | 1 | Return from a pseudo non-maskable service routine |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | An eligible request is pending |
| ack_o | output | 1 | One-cycle acceptance strobe |
| vec_o | output | 5 | Accepted source number |

## Verification
The bench targets four corner cases:

- **Set against clear.** A hardware set and a software clear land on one latch in the same cycle. A design that favours the clear silently drops a request.
- **Writing 1 to a latch.** A write of 1 to a latch byte must not create a request. A design that stores the data would raise `irq_o` with no source.
- **Nesting.** A watchdog request arrives during software-interrupt service. A nesting bug accepts it early, before `retn_i`.
- **Master enable priority.** An accept coincides with a bus write of the master enable, and returns restore from the saved copy. Getting this order wrong either leaves interrupts enabled inside a handler or leaves them off after `reti_i`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BYTE_W         = 8;
  localparam int SWI_SRC        = 0;
  localparam int WDT_SRC        = 1;
  localparam int FIRST_MASKABLE = 2;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:1] set_i,
  input  logic [N_SRC-1:1] sw_clr_i,
  input  logic [N_SRC-1:1] acc_clr_i,
  output logic [N_SRC-1:1] lat_o
);
  for (genvar k = 1; k < N_SRC; k++) begin : g_lat
    // set dominates both clears so no request is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_o[k] <= 1'b0;
      else         lat_o[k] <= set_i[k] | (lat_o[k] & ~sw_clr_i[k] & ~acc_clr_i[k]);
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int NB   = N_SRC / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              acc_i,
  input  logic              reti_i,
  input  logic              retn_i,
  input  logic              saved_i,
  output logic              ime_o,
  output logic [N_SRC-1:1]  en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ime_o <= 1'b0;
    else if (acc_i)  ime_o <= 1'b0;
    else if (retn_i) ime_o <= 1'b1;
    else if (reti_i) ime_o <= saved_i;
    else if (wr_i[0]) ime_o <= wdata_i[0];
  end

  for (genvar k = 1; k < N_SRC; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              en_o[k] <= 1'b0;
      else if (wr_i[k/BYTE_W])  en_o[k] <= wdata_i[k%BYTE_W];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar k = 1; k < N; k++) begin : g_chain
    assign seen[k] = seen[k-1] | req_i[k-1];
  end
  assign grant = req_i & ~seen;
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++)
      if (grant[k]) idx_o = idx_o | IW'(k);
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          retn_i,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic          ime_i,
  output logic          acc_o,
  output logic          nmi_busy_o,
  output logic          saved_o,
  output logic          ack_o,
  output logic [IW-1:0] vec_o
);
  logic is_nmi;

  assign acc_o  = take_i & any_i;
  assign is_nmi = idx_i < IW'(FIRST_MASKABLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_busy_o <= 1'b0;
      saved_o    <= 1'b0;
      ack_o      <= 1'b0;
      vec_o      <= '0;
    end else begin
      ack_o <= acc_o;
      if (acc_o) vec_o <= idx_i;
      if (acc_o && is_nmi)  nmi_busy_o <= 1'b1;
      else if (retn_i)      nmi_busy_o <= 1'b0;
      if (acc_o && !is_nmi) saved_o <= ime_i;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int NB   = N_SRC / BYTE_W,
  localparam int AW   = $clog2(NB) + 1,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:1]  hw_req_i,
  input  logic              swi_i,
  input  logic              take_i,
  input  logic              reti_i,
  input  logic              retn_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [IW-1:0]     vec_o
);
  logic [N_SRC-1:1] lat_q, en_q, sw_clr, acc_clr;
  logic [N_SRC-1:0] pend, rd_view;
  logic [NB-1:0]    wr_en_byte;
  logic [AW-2:0]    sel;
  logic             bank_lat, ime_q, nmi_busy, saved_ime, acc, any;
  logic [IW-1:0]    win;

  assign bank_lat = addr_i[AW-1];
  assign sel      = addr_i[AW-2:0];

  for (genvar b = 0; b < NB; b++) begin : g_wr
    assign wr_en_byte[b] = wr_en_i & ~bank_lat & (sel == (AW-1)'(b));
  end

  for (genvar k = 1; k < N_SRC; k++) begin : g_clr
    assign sw_clr[k]  = wr_en_i & bank_lat & (sel == (AW-1)'(k/BYTE_W)) & ~wdata_i[k%BYTE_W];
    assign acc_clr[k] = acc & (win == IW'(k));
  end

  // pseudo-NMI sources skip enables but respect nesting
  assign pend[SWI_SRC] = swi_i & ~nmi_busy;
  assign pend[WDT_SRC] = lat_q[WDT_SRC] & ~nmi_busy;
  for (genvar k = FIRST_MASKABLE; k < N_SRC; k++) begin : g_pend
    assign pend[k] = lat_q[k] & en_q[k] & ime_q;
  end

  irq_latch_bank #(.N_SRC(N_SRC)) i_latch_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (hw_req_i),
    .sw_clr_i  (sw_clr),
    .acc_clr_i (acc_clr),
    .lat_o     (lat_q)
  );

  irq_enable_regs #(.N_SRC(N_SRC)) i_enable_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_byte),
    .wdata_i (wdata_i),
    .acc_i   (acc),
    .reti_i  (reti_i),
    .retn_i  (retn_i),
    .saved_i (saved_ime),
    .ime_o   (ime_q),
    .en_o    (en_q)
  );

  irq_prio_enc #(.N(N_SRC)) i_prio_enc (
    .req_i (pend),
    .any_o (any),
    .idx_o (win)
  );

  irq_accept_ctrl #(.N_SRC(N_SRC)) i_accept_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_i),
    .retn_i     (retn_i),
    .any_i      (any),
    .idx_i      (win),
    .ime_i      (ime_q),
    .acc_o      (acc),
    .nmi_busy_o (nmi_busy),
    .saved_o    (saved_ime),
    .ack_o      (ack_o),
    .vec_o      (vec_o)
  );

  assign irq_o   = any;
  assign rd_view = bank_lat ? {lat_q, 1'b0} : {en_q, ime_q};
  assign rdata_o = rd_view[sel*BYTE_W +: BYTE_W];
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IW   = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             take_i,
  input logic             retn_i,
  input logic [N_SRC-1:1] hw_req_i,
  input logic [N_SRC-1:1] lat_q,
  input logic             ime_q,
  input logic             nmi_busy,
  input logic             ack_o,
  input logic [IW-1:0]    vec_o
);
  // R1
  latch_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lat_q & ~$past(lat_q)) & ~$past(hw_req_i)) == '0);

  // R6
  ack_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(take_i));

  // R9
  ack_ime_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ime_q);

  // R5
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && vec_o >= IW'(FIRST_MASKABLE)) |-> $past(ime_q));

  // R8
  nmi_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && vec_o < IW'(FIRST_MASKABLE)) |-> !$past(nmi_busy));

  // R10
  retn_ime_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(retn_i) && !ack_o) |-> (ime_q && !nmi_busy));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC)) i_irq_ctrl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .take_i   (take_i),
  .retn_i   (retn_i),
  .hw_req_i (hw_req_i),
  .lat_q    (lat_q),
  .ime_q    (ime_q),
  .nmi_busy (nmi_busy),
  .ack_o    (ack_o),
  .vec_o    (vec_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:1] hw_req_i = '0;
  logic        swi_i = 1'b0, take_i = 1'b0, reti_i = 1'b0, retn_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o, ack_o;
  logic [4:0]  vec_o;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [31:0] m_lat = '0, m_en = '0;
  logic        m_ime = 1'b0, m_saved = 1'b0, m_busy = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_req_i(hw_req_i), .swi_i(swi_i),
    .take_i(take_i), .reti_i(reti_i), .retn_i(retn_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .ack_o(ack_o), .vec_o(vec_o)
  );

  task automatic check(input string lbl, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", lbl, act, exp);
    end
  endtask

  function automatic logic [31:0] m_pend(input logic swi);
    logic [31:0] p;
    p[0] = swi & ~m_busy;
    p[1] = m_lat[1] & ~m_busy;
    for (int k = 2; k < N; k++) p[k] = m_lat[k] & m_en[k] & m_ime;
    return p;
  endfunction

  function automatic int m_low(input logic [31:0] p);
    for (int k = 0; k < N; k++) if (p[k]) return k;
    return 0;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [31:0] v;
    v = a[2] ? {m_lat[31:1], 1'b0} : {m_en[31:1], m_ime};
    return v[a[1:0]*8 +: 8];
  endfunction

  function automatic logic [31:1] hwb(input int k);
    return 31'(1) << (k - 1);
  endfunction

  // drive one cycle, check comb outputs, advance, update model, check ack/vec
  task automatic step(input logic [31:1] hw, input logic swi, input logic take,
                      input logic reti, input logic retn, input logic wr,
                      input logic [2:0] a, input logic [7:0] wd);
    logic [31:0] p, nl, ne;
    logic        any, acc, nime, nsaved, nbusy;
    int          win;
    hw_req_i = hw; swi_i = swi; take_i = take; reti_i = reti; retn_i = retn;
    wr_en_i = wr; addr_i = a; wdata_i = wd;
    #1;
    p = m_pend(swi); any = |p; win = m_low(p); acc = take & any;
    check("R5/R7/R8 irq_o", 32'(irq_o), 32'(any));
    check("R3 rdata_o", 32'(rdata_o), 32'(m_read(a)));
    nl = '0; ne = m_en;
    for (int k = 1; k < N; k++) begin
      nl[k] = hw[k] | (m_lat[k] & ~(wr & a[2] & (a[1:0] == 2'(k/8)) & ~wd[k%8])
                                 & ~(acc & (win == k)));
      if (wr && !a[2] && a[1:0] == 2'(k/8)) ne[k] = wd[k%8];
    end
    if (acc) nime = 1'b0;
    else if (retn) nime = 1'b1;
    else if (reti) nime = m_saved;
    else if (wr && a == 3'd0) nime = wd[0];
    else nime = m_ime;
    nsaved = (acc && win >= 2) ? m_ime : m_saved;
    nbusy  = (acc && win < 2) ? 1'b1 : (retn ? 1'b0 : m_busy);
    @(posedge clk_i);
    m_lat = nl; m_en = ne; m_ime = nime; m_saved = nsaved; m_busy = nbusy;
    @(negedge clk_i);
    hw_req_i = '0; swi_i = 0; take_i = 0; reti_i = 0; retn_i = 0; wr_en_i = 0;
    check("R6 ack_o", 32'(ack_o), 32'(acc));
    if (acc) check("R6 vec_o", 32'(vec_o), 32'(win));
  endtask

  task automatic idle();
    step('0, 0, 0, 0, 0, 0, 3'd0, 8'h00);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] exp, input string lbl);
    addr_i = a; #1;
    check(lbl, 32'(rdata_o), 32'(exp));
  endtask

  task automatic expect_irq(input logic exp, input string lbl);
    #1; check(lbl, 32'(irq_o), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state, R1 / R3
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, "R1/R3 reset read");
    expect_irq(1'b0, "R1 reset irq");

    // latch set and read position
    step(hwb(9), 0, 0, 0, 0, 0, 3'd0, 8'h00);
    expect_rd(3'd5, 8'h02, "R1/R3 latch 9 position");
    // write of ones does not set, set beats clear
    step('0, 0, 0, 0, 0, 1, 3'd5, 8'hFF);
    expect_rd(3'd5, 8'h02, "R4 write-one keeps");
    step(hwb(9), 0, 0, 0, 0, 1, 3'd5, 8'h00);
    expect_rd(3'd5, 8'h02, "R4 set beats clear");
    step('0, 0, 0, 0, 0, 1, 3'd5, 8'h00);
    expect_rd(3'd5, 8'h00, "R4 clear");

    // masking and priority
    step(hwb(5) | hwb(3), 0, 0, 0, 0, 0, 3'd0, 8'h00);
    step('0, 0, 0, 0, 0, 1, 3'd0, 8'h28);
    expect_rd(3'd0, 8'h28, "R11 enable write");
    expect_irq(1'b0, "R5 master enable off");
    step('0, 0, 0, 0, 0, 1, 3'd0, 8'h29);
    expect_irq(1'b1, "R5 enabled pending");
    step('0, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    check("R6 ack after take", 32'(ack_o), 32'd1);
    check("R6 lowest wins", 32'(vec_o), 32'd3);
    expect_rd(3'd0, 8'h28, "R9 accept clears master");
    expect_rd(3'd4, 8'h20, "R2 accepted latch cleared");
    idle();
    check("R6 single-cycle ack", 32'(ack_o), 32'd0);
    expect_irq(1'b0, "R9 masked in service");
    step('0, 0, 0, 1, 0, 0, 3'd0, 8'h00);
    expect_rd(3'd0, 8'h29, "R9 reti restores");

    // pseudo-NMI class
    step('0, 0, 0, 0, 0, 1, 3'd0, 8'h28);
    step('0, 1, 1, 0, 0, 0, 3'd0, 8'h00);
    check("R7 swi accepted masked", 32'(vec_o), 32'd0);
    step(hwb(1), 1, 0, 0, 0, 0, 3'd0, 8'h00);
    expect_irq(1'b0, "R8 no nesting");
    expect_rd(3'd4, 8'h22, "R8 watchdog latched");
    step('0, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    check("R8 take ignored", 32'(ack_o), 32'd0);
    step('0, 0, 0, 0, 1, 0, 3'd0, 8'h00);
    expect_rd(3'd0, 8'h29, "R10 retn sets master");
    step('0, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    check("R10/R7 watchdog wins", 32'(vec_o), 32'd1);
    step('0, 0, 0, 0, 1, 0, 3'd0, 8'h00);

    // accept beats enable write
    step('0, 0, 1, 0, 0, 1, 3'd0, 8'h29);
    check("R11 accept with write", 32'(vec_o), 32'd5);
    expect_rd(3'd0, 8'h28, "R11 accept over write");
    // watchdog enable bit stored but irrelevant
    step('0, 0, 0, 0, 0, 1, 3'd0, 8'h2A);
    expect_rd(3'd0, 8'h2A, "R3/R7 bit1 stored");
    step('0, 0, 0, 0, 0, 1, 3'd0, 8'h28);
    step(hwb(1), 0, 0, 0, 0, 0, 3'd0, 8'h00);
    expect_irq(1'b1, "R7 watchdog bypasses enables");
    step('0, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    step('0, 0, 0, 0, 1, 0, 3'd0, 8'h00);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:1] hw;
      hw = 31'($urandom & $urandom & $urandom & $urandom);
      step(hw, ($urandom % 16) == 0, ($urandom % 3) == 0, ($urandom % 16) == 0,
           ($urandom % 16) == 0, ($urandom % 6) == 0, 3'($urandom), 8'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule